// File: doc/BRIEF.md
# Self-Timed Word Program Controller

This block owns the timed phase of a word write in a small serial non-volatile memory. The serial front end hands it a finished write request: a word address, a data word, and a launch handshake. When the request is taken and the write-protect input is low, the block starts an internal timer that models the erase-and-program time. It holds its ready/busy status output low for the whole timer window. When the window ends, it stores the word in the array and raises ready/busy again. The timer length is a parameter in system clock ticks, so a short value can be used in simulation and a value near 10 ms of clock ticks in silicon.

The write-protect input is live. If it is high when the request is taken, the request is consumed and dropped: no busy window starts and the array is not touched. If it is seen high during the timer window, the program is cut short, the target word is overwritten with a fixed marker pattern, and ready/busy goes high. After any program cycle ends, normally or by abort, the block takes no new request until chip select is seen high. During a cycle, chip select is otherwise ignored. The block also drives a status-display enable and level, which the front end puts on its data-out line. The enable is set when chip select falls while the serial clock is low after a write has been launched, and it clears when chip select rises.

The request side is a valid/ready stream. The source raises `req_valid` with a stable address and data and holds them until a cycle in which `req_ready` is also high; the transfer happens on that clock edge. `req_ready` is low while a cycle is running or waiting for chip select, and that is the only back-pressure. A source may keep `req_valid` high through it, and nothing is taken until ready returns.

Top module: `prog_cycle_ctrl`

## Requirements
- R1: After reset, `ready_busy` is 1, `req_ready` is 1 and `st_show` is 0.
- R2: A request taken with `wr_protect` low drives `ready_busy` low from the cycle after the transfer edge. It stays low for exactly CYCLE_TICKS clock cycles when not aborted.
- R3: When a cycle completes normally, the word at the request address reads back on `rd_data` as the request data.
- R4: A request taken while `wr_protect` is high leaves `ready_busy` high and `req_ready` high, and leaves the stored word unchanged.
- R5: `wr_protect` sampled high during the busy window ends it: `ready_busy` is 1 on the next cycle, and the target word reads back as CORRUPT_WORD (default 16'hDEAD).
- R6: After a cycle ends (normal or aborted), `req_ready` stays 0 until `cs` is sampled high. It is 1 on the cycle after that sample.
- R7: Toggling `cs` during the busy window changes neither its length nor the stored result.
- R8: With a write launched, `cs` sampled falling (1 then 0) while `sk` is 0 sets `st_show` on the next cycle, and `st_level` equals `ready_busy`. A fall with `sk` at 1 does not set it. `cs` high clears it on the next cycle.
- R9: While busy, `req_ready` is 0, and a request held valid then is not taken and does not change the word being programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Word address of the request |
| req_data | input | DATA_W | Data word of the request |
| wr_protect | input | 1 | Write protect; refuses a request, aborts a running cycle |
| cs | input | 1 | Chip select level, 1 = deselected |
| sk | input | 1 | Serial clock level, sampled in the system clock |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array word at `rd_addr` (combinational) |
| ready_busy | output | 1 | 1 = ready, 0 = program cycle running |
| st_show | output | 1 | Front end should put the status level on data-out |
| st_level | output | 1 | Status level for data-out (1 = ready) |

## Verification
The properties assume that `cs`, `sk` and `wr_protect` are already synchronous levels in the system clock domain, and that a request source keeps its payload steady while valid. The bench drives every input on the falling clock edge and releases `req_valid` right after the transfer edge, so each sampled level is unambiguous. The length property assumes CYCLE_TICKS is at least 1 and fits its counter. The bench uses a short cycle of 8 ticks so that many complete cycles fit in one run.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [1:0] {
    PCC_IDLE  = 2'd0,
    PCC_BUSY  = 2'd1,
    PCC_DONE  = 2'd2,
    PCC_ABORT = 2'd3
  } pcc_state_e;
endpackage

// File: rtl/pcc_timer.sv
module pcc_timer #(
  parameter int TICKS = 2000000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || start) cnt <= '0;
    else if (run)     cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == CW'(TICKS - 1));
endmodule

// File: rtl/pcc_array.sv
module pcc_array #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/pcc_ctrl.sv
module pcc_ctrl
  import pcc_pkg::*;
#(
  parameter int                ADDR_W       = 9,
  parameter int                DATA_W       = 16,
  parameter logic [DATA_W-1:0] CORRUPT_WORD = 16'hDEAD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              wr_protect,
  input  logic              cs,
  input  logic              tmr_expire,
  output logic              tmr_start,
  output logic              tmr_run,
  output logic              cm_we,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [DATA_W-1:0] cm_data,
  output pcc_state_e        state
);
  logic [ADDR_W-1:0] tgt_addr;
  logic [DATA_W-1:0] tgt_data;
  logic              take;

  assign take      = (state == PCC_IDLE) && req_valid;
  assign tmr_start = take && !wr_protect;
  assign tmr_run   = (state == PCC_BUSY);
  assign cm_we     = tmr_run && (wr_protect || tmr_expire);
  assign cm_addr   = tgt_addr;
  assign cm_data   = wr_protect ? CORRUPT_WORD : tgt_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PCC_IDLE;
      tgt_addr <= '0;
      tgt_data <= '0;
    end else begin
      unique case (state)
        PCC_IDLE: begin
          if (tmr_start) begin
            state    <= PCC_BUSY;
            tgt_addr <= req_addr;
            tgt_data <= req_data;
          end
        end
        PCC_BUSY: begin
          if (wr_protect)      state <= PCC_ABORT;
          else if (tmr_expire) state <= PCC_DONE;
        end
        PCC_DONE, PCC_ABORT: begin
          if (cs) state <= PCC_IDLE;
        end
        default: state <= PCC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcc_status.sv
module pcc_status
  import pcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cs,
  input  logic       sk,
  input  pcc_state_e state,
  output logic       st_show,
  output logic       st_level
);
  logic cs_q;
  logic armed;

  assign armed    = (state != PCC_IDLE);
  assign st_level = (state != PCC_BUSY);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q    <= 1'b1;
      st_show <= 1'b0;
    end else begin
      cs_q <= cs;
      if (cs)                               st_show <= 1'b0;
      else if (cs_q && !sk && armed)        st_show <= 1'b1;
    end
  end
endmodule

// File: rtl/prog_cycle_ctrl.sv
module prog_cycle_ctrl
  import pcc_pkg::*;
#(
  parameter int                ADDR_W       = 9,
  parameter int                DATA_W       = 16,
  parameter int                CYCLE_TICKS  = 2000000,
  parameter logic [DATA_W-1:0] CORRUPT_WORD = 16'hDEAD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              wr_protect,
  input  logic              cs,
  input  logic              sk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ready_busy,
  output logic              st_show,
  output logic              st_level
);
  pcc_state_e        state;
  logic              tmr_start, tmr_run, tmr_expire;
  logic              cm_we;
  logic [ADDR_W-1:0] cm_addr;
  logic [DATA_W-1:0] cm_data;

  pcc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CORRUPT_WORD(CORRUPT_WORD)
  ) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .wr_protect(wr_protect), .cs(cs),
    .tmr_expire(tmr_expire), .tmr_start(tmr_start), .tmr_run(tmr_run),
    .cm_we(cm_we), .cm_addr(cm_addr), .cm_data(cm_data), .state(state)
  );

  pcc_timer #(.TICKS(CYCLE_TICKS)) u_timer (
    .clk(clk), .rst(rst), .start(tmr_start), .run(tmr_run),
    .expire(tmr_expire)
  );

  pcc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(cm_we), .waddr(cm_addr), .wdata(cm_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  pcc_status u_status (
    .clk(clk), .rst(rst), .cs(cs), .sk(sk), .state(state),
    .st_show(st_show), .st_level(st_level)
  );

  assign req_ready  = (state == PCC_IDLE);
  assign ready_busy = (state != PCC_BUSY);
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
  parameter int CYCLE_TICKS = 2000000
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic wr_protect,
  input logic cs,
  input logic ready_busy,
  input logic st_show,
  input logic st_level
);
  logic [31:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)              run_len <= '0;
    else if (!ready_busy) run_len <= run_len + 1'b1;
    else                  run_len <= '0;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    $fell(rst) |-> ready_busy && req_ready && !st_show);

  p_launch_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !wr_protect) |=> !ready_busy);

  p_cycle_len_r2: assert property (@(posedge clk) disable iff (rst)
    (ready_busy && !$past(ready_busy) && !$past(wr_protect))
      |-> run_len == CYCLE_TICKS);

  p_refuse_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && wr_protect) |=> ready_busy && req_ready);

  p_abort_r5: assert property (@(posedge clk) disable iff (rst)
    (!ready_busy && wr_protect) |=> ready_busy && !req_ready);

  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    !ready_busy |-> !req_ready);

  p_show_clear_r8: assert property (@(posedge clk) disable iff (rst)
    cs |=> !st_show);

  p_show_level_r8: assert property (@(posedge clk) disable iff (rst)
    st_show |-> st_level == ready_busy);
endmodule

bind prog_cycle_ctrl pcc_checker #(.CYCLE_TICKS(CYCLE_TICKS)) u_pcc_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .wr_protect(wr_protect), .cs(cs), .ready_busy(ready_busy),
  .st_show(st_show), .st_level(st_level)
);

// File: tb/prog_cycle_ctrl_bench.sv
module prog_cycle_ctrl_bench;
  localparam int          AW    = 9;
  localparam int          DW    = 16;
  localparam int          TICKS = 8;
  localparam logic [15:0] BAD   = 16'hDEAD;

  typedef struct packed {
    logic [8:0]  addr;
    logic [15:0] data;
    logic        wp;
    logic        abort;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{9'h000, 16'h1234, 1'b0, 1'b0, 16'h1234},
    '{9'h1FF, 16'h8001, 1'b0, 1'b0, 16'h8001},
    '{9'h000, 16'hFFFF, 1'b1, 1'b0, 16'h1234},
    '{9'h010, 16'hAAAA, 1'b0, 1'b1, BAD},
    '{9'h010, 16'h5555, 1'b0, 1'b0, 16'h5555},
    '{9'h1FF, 16'h0000, 1'b1, 1'b0, 16'h8001}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          wr_protect = 1'b0;
  logic          cs = 1'b1;
  logic          sk = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          ready_busy, st_show, st_level;

  int  nchk = 0;
  int  nfail = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  prog_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CYCLE_TICKS(TICKS),
                    .CORRUPT_WORD(BAD)) u_prog_cycle_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .wr_protect(wr_protect),
    .cs(cs), .sk(sk), .rd_addr(rd_addr), .rd_data(rd_data),
    .ready_busy(ready_busy), .st_show(st_show), .st_level(st_level)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic wp);
    @(negedge clk);
    cs = 1'b0; req_valid = 1'b1; req_addr = a; req_data = d; wr_protect = wp;
    @(negedge clk);
    req_valid = 1'b0; wr_protect = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready_busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic release_cs();
    cs = 1'b1;
    @(negedge clk);
  endtask

  task automatic readback(input logic [AW-1:0] a, input logic [DW-1:0] e,
                          input string tag);
    rd_addr = a;
    #1;
    chk(rd_data == e, tag, rd_data, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog R2 cycle never ended actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ready_busy && req_ready && !st_show, "R1 reset state",
        {ready_busy, req_ready, st_show}, 3'b110);

    // Vector table: normal, refused, aborted writes
    foreach (VECS[i]) begin
      launch(VECS[i].addr, VECS[i].data, VECS[i].wp);
      if (VECS[i].wp) begin
        chk(ready_busy && req_ready, "R4 refused stays ready",
            {ready_busy, req_ready}, 2'b11);
      end else begin
        chk(!ready_busy, "R2 busy after launch", ready_busy, 0);
        if (VECS[i].abort) begin
          wr_protect = 1'b1;
          @(negedge clk);
          wr_protect = 1'b0;
          chk(ready_busy && !req_ready, "R5 abort ends busy",
              {ready_busy, req_ready}, 2'b10);
        end else begin
          wait_ready(n);
          chk(n == TICKS, "R2 busy length", n, TICKS);
          chk(!req_ready, "R6 held until cs high", req_ready, 0);
        end
      end
      release_cs();
      chk(req_ready, "R6 ready after cs high", req_ready, 1);
      readback(VECS[i].addr, VECS[i].exp,
               VECS[i].abort ? "R5 corrupt marker" :
               VECS[i].wp ? "R4 word unchanged" : "R3 word committed");
    end

    // R7: cs toggling during the busy window
    launch(9'h021, 16'hC3C3, 1'b0);
    n = 0;
    while (!ready_busy) begin
      n++;
      cs = ~cs;
      @(negedge clk);
    end
    chk(n == TICKS, "R7 length with cs toggling", n, TICKS);
    release_cs();
    readback(9'h021, 16'hC3C3, "R7 result with cs toggling");

    // R8: status display with cs falling while sk low
    launch(9'h020, 16'hBEEF, 1'b0);
    cs = 1'b1; sk = 1'b0;
    @(negedge clk);
    cs = 1'b0;
    @(negedge clk);
    chk(st_show && !st_level, "R8 shows busy", {st_show, st_level}, 2'b10);
    wait_ready(n);
    chk(st_show && st_level, "R8 shows ready", {st_show, st_level}, 2'b11);
    release_cs();
    chk(!st_show, "R8 cleared by cs high", st_show, 0);

    // R8: cs falling while sk high does not enable display
    launch(9'h022, 16'h0F0F, 1'b0);
    cs = 1'b1;
    @(negedge clk);
    sk = 1'b1; cs = 1'b0;
    @(negedge clk);
    chk(!st_show, "R8 no display when sk high", st_show, 0);
    sk = 1'b0;
    wait_ready(n);
    release_cs();

    // R9: request held valid during busy is not taken
    launch(9'h030, 16'h1111, 1'b0);
    req_valid = 1'b1; req_addr = 9'h030; req_data = 16'h2222;
    @(negedge clk);
    chk(!req_ready, "R9 not ready while busy", req_ready, 0);
    wait_ready(n);
    req_valid = 1'b0;
    release_cs();
    readback(9'h030, 16'h1111, "R9 busy request ignored");

    // R6: cs already high when the cycle ends
    launch(9'h040, 16'h4444, 1'b0);
    cs = 1'b1;
    wait_ready(n);
    chk(!req_ready, "R6 done state one cycle", req_ready, 0);
    @(negedge clk);
    chk(req_ready, "R6 ready with cs held high", req_ready, 1);
    readback(9'h040, 16'h4444, "R3 word committed cs high");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule